// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block keeps the shared interrupt control word for a seven-channel DMA controller and drives the processor's interrupt request line. Each channel engine signals the end of a transfer with a single-cycle pulse. If that channel is enabled for interrupts, the pulse latches the channel's pending flag. Whenever a channel completes, or the processor writes the word, the block recomputes a summary (master) flag. The request line pulses for one cycle only when that master flag goes from clear to set.

The processor reaches two common registers through a small synchronous port. Select 0 is a 32-bit priority/enable word, which is stored exactly as written. Select 1 is the interrupt control word. Reads are combinational from the selected register.

Interrupt word layout:
- bits 0–14: general storage, written as given.
- bit 15: force.
- bits 16–22: per-channel enables.
- bit 23: master enable.
- bits 24–30: per-channel flags.
- bit 31: master flag.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, both registers read as zero and `irq_o` is low.
- R2: A write with `reg_sel`=0 stores all 32 bits of `wr_data` into the priority word, which then reads back unchanged and does not alter the interrupt word.
- R3: A write with `reg_sel`=1 loads bits 0–23 of the interrupt word from `wr_data`. Bit 31 of the data has no direct effect on the word.
- R4: In that write, each flag bit 24+n (n = 0..6) is cleared where `wr_data` holds a 1 and kept where it holds a 0.
- R5: A pulse on `done_i[n]` sets flag bit 24+n only if enable bit 16+n is set. The enable value used is the one left after any write in the same cycle.
- R6: While force bit 15 is set, the master flag (bit 31) reads as 1 after any update.
- R7: On every completion pulse or interrupt-word write, bit 31 becomes force OR (bit 23 AND any channel with both enable and flag set). At all other times bit 31 holds its value.
- R8: `irq_o` is high for exactly the one cycle after an update that moves bit 31 from 0 to 1. It stays low while bit 31 stays set and when bit 31 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 7 | One-cycle completion pulse per channel, bit n = channel n |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = priority word, 1 = interrupt word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request pulse to the processor |

## Verification
The bound checker watches several properties on every cycle:
- a request pulse always matches a fresh 0-to-1 change of the master flag;
- a flag only appears with a completion pulse on an enabled channel;
- the force bit implies the master flag;
- the master flag holds when nothing updates it;
- an interrupt-word write lands in the low 24 bits.

Some behaviours only the bench scenarios can show: flags clearing from written ones, the priority word being stored in full, and the exact master value across every combination of force, master enable, channel enable and completion on each channel.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NCH = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  done_i,
  input  logic            wr_en,
  input  logic            reg_sel,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            irq_o
);
  localparam int EN_LO  = 16;
  localparam int FL_LO  = 24;
  localparam int FORCE  = 15;
  localparam int MEN    = 23;
  localparam int MFLAG  = 31;

  logic [31:0] prio_q, ctl_q, ctl_d;
  logic        wr_ctl, upd, master;

  assign wr_ctl = wr_en & reg_sel;
  assign upd    = wr_ctl | (|done_i);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d[MEN:0] = wr_data[MEN:0];
      ctl_d[FL_LO+NCH-1:FL_LO] = ctl_q[FL_LO+NCH-1:FL_LO] & ~wr_data[FL_LO+NCH-1:FL_LO];
    end
    ctl_d[FL_LO+NCH-1:FL_LO] = ctl_d[FL_LO+NCH-1:FL_LO] | (done_i & ctl_d[EN_LO+NCH-1:EN_LO]);
    master = ctl_d[FORCE] |
             (ctl_d[MEN] & |(ctl_d[EN_LO+NCH-1:EN_LO] & ctl_d[FL_LO+NCH-1:FL_LO]));
    if (upd) ctl_d[MFLAG] = master;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      ctl_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en && !reg_sel) prio_q <= wr_data;
      ctl_q <= ctl_d;
      irq_o <= ctl_d[MFLAG] & ~ctl_q[MFLAG];
    end
  end

  assign rd_data = reg_sel ? ctl_q : prio_q;
endmodule

module dma_irq_ctrl_chk #(
  parameter int NCH = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  done_i,
  input logic            wr_en,
  input logic            reg_sel,
  input logic [31:0]     wr_data,
  input logic [31:0]     ctl_q,
  input logic            irq_o
);
  p_irq_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctl_q[31] && !$past(ctl_q[31])));

  p_flag_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q[24+NCH-1:24] & ~$past(ctl_q[24+NCH-1:24])) &
     ~($past(done_i) & ctl_q[16+NCH-1:16])) == '0);

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[15] |-> ctl_q[31]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && reg_sel) && done_i == '0) |=> $stable(ctl_q[31]));

  p_wr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> (ctl_q[23:0] == $past(wr_data[23:0])));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .wr_en(wr_en),
  .reg_sel(reg_sel), .wr_data(wr_data), .ctl_q(ctl_q), .irq_o(irq_o));

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  done_i = '0;
  logic        wr_en = 0, reg_sel = 1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0, fails = 0;
  logic [31:0] m_ctl = '0, m_prio = '0;
  logic        m_irq = 0;

  dma_irq_ctrl i_dma_irq_ctrl (.clk, .rst_n, .done_i, .wr_en, .reg_sel,
                               .wr_data, .rd_data, .irq_o);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [6:0] d, input logic w, input logic s, input logic [31:0] wd);
    logic [31:0] n;
    n = m_ctl;
    if (w && s) begin
      n[23:0] = wd[23:0];
      n[30:24] = n[30:24] & ~wd[30:24];
    end
    if (w && !s) m_prio = wd;
    n[30:24] = n[30:24] | (d & n[22:16]);
    if ((w && s) || d != 0)
      n[31] = n[15] | (n[23] & (|(n[22:16] & n[30:24])));
    m_irq = n[31] & ~m_ctl[31];
    m_ctl = n;
    done_i = d; wr_en = w; reg_sel = s; wr_data = wd;
    @(posedge clk); #1;
    done_i = '0; wr_en = 0;
    @(negedge clk);
    reg_sel = 1; #1;
    chk("R3/R4/R5/R7 ctl", rd_data, m_ctl);
    chk("R8 irq", {31'b0, irq_o}, {31'b0, m_irq});
    reg_sel = 0; #1;
    chk("R2 prio", rd_data, m_prio);
    reg_sel = 1;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    reg_sel = 1; #1; chk("R1 ctl reset", rd_data, 32'h0);
    reg_sel = 0; #1; chk("R1 prio reset", rd_data, 32'h0);
    chk("R1 irq reset", {31'b0, irq_o}, 32'h0);

    cyc('0, 1, 0, 32'hA5C3_0F96);
    cyc('0, 1, 1, 32'h8012_3456);
    cyc('0, 1, 0, 32'hFFFF_FFFF);

    for (int n = 0; n < 7; n++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] wd;
        wd = 32'h7F00_0000 | (c[0] ? 32'h8000 : 0) | (c[1] ? 32'h0080_0000 : 0) |
             (c[2] ? (32'h1 << (16 + n)) : 0) | (32'h1 << n);
        cyc('0, 1, 1, wd);
        cyc(c[3] ? (7'h1 << n) : 7'h0, 0, 1, '0);
        cyc(7'h1 << n, 0, 1, '0);
        cyc('0, 0, 1, '0);
      end
    end

    cyc('0, 1, 1, 32'h7FBF_0000);
    cyc(7'h7F, 0, 1, '0);
    cyc('0, 1, 1, 32'h0100_0000);
    cyc('0, 1, 1, 32'h7E00_0000);
    cyc(7'h04, 1, 1, 32'h7F80_0004);
    cyc('0, 1, 1, 32'h0000_8000);
    cyc('0, 1, 1, 32'h0000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule